// File: doc/BRIEF.md
# Sectored flash array emulator

A synthesizable model of a small NOR-style flash array for simulation and prototyping. The array is divided into eleven sectors of unequal size with a bottom-boot layout: the small sectors sit at the low addresses. All sizes are multiples of a parameterised unit so that the array stays small. A single clocked request port accepts program, sector-erase, chip-erase and abort requests. Each accepted request is acknowledged. Program and erase then keep the block busy for a fixed number of cycles, and the array changes when that busy window ends.

Programming can only clear bits: the stored word becomes the old word ANDed with the written data. Erase sets a sector back to all ones. A per-sector protection mask blocks both program and erase, unless the temporary-unprotect input is high when the request is accepted. An identification mode replaces array data on the read port. In that mode the read port returns a manufacturer code, a device code, or the protection bit of the addressed sector.

Top module: `flash_array_emu`

## Requirements
- R1: With unit U = SEC_UNIT words, the sectors, in ascending address order, are 2U, U, U and 4U words, followed by seven sectors of 8U words. The array is 64U words in total.
- R2: After rst_ni is asserted, every word reads as all ones, and busy_o and ack_o are low.
- R3: A program request (op_i = 2'b00) to an unprotected sector sets the addressed word to its old value ANDed with wdata_i. No other word changes.
- R4: A sector-erase request (op_i = 2'b01) sets every word of the sector holding addr_i to all ones. No other sector changes.
- R5: A chip-erase request (op_i = 2'b10) sets every word of every unprotected sector to all ones.
- R6: Bit s of prot_i protects sector s. A program or erase request accepted while the target sector is protected leaves that sector unchanged.
- R7: If unprot_i is high when a request is accepted, protection is lifted for that request only. Requests accepted after unprot_i is released are blocked again.
- R8: While id_mode_i is high, rdata_o depends on the word offset of addr_i within its sector. Offset 0 returns 0052h, offset 1 returns DEV_ID, offset 2 returns prot_i of that sector on bit 0 with all other bits zero, and every other offset returns 0. The array contents are not affected.
- R9: A request accepted while the block is idle raises ack_o for one cycle and busy_o for exactly BUSY_CYC cycles. Both rise on the clock edge that samples the request. The array reflects the operation once busy_o falls.
- R10: A program or erase request made while busy_o is high gets no ack_o and has no effect.
- R11: An abort request (op_i = 2'b11) is always acknowledged. It clears busy_o on the next edge, and the operation in progress is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, sampled each clock edge |
| op_i | input | 2 | Request kind: 00 program, 01 sector erase, 10 chip erase, 11 abort |
| addr_i | input | AW | Word address for requests and reads |
| wdata_i | input | DW | Program data |
| prot_i | input | 11 | Per-sector protection mask |
| unprot_i | input | 1 | Temporary lift of protection |
| id_mode_i | input | 1 | Identification readback select |
| ack_o | output | 1 | One-cycle acknowledge of an accepted request |
| busy_o | output | 1 | Program or erase in progress |
| rdata_o | output | DW | Array word, or identification data in ID mode |

## Verification
The bench uses the default build: SEC_UNIT = 8 (a 512-word array), BUSY_CYC = 4 and 16-bit words. With a unit of 8 words, the last word of each small sector and the first word of its neighbour are easy to address. This lets erase and program be probed on both sides of each boundary among the first four sectors. A four-cycle busy window is long enough to issue a competing request and an abort in its middle cycles.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;
  localparam int NSEC = 11;
  localparam int NUNITS = 64;

  typedef enum logic [1:0] {
    OP_PROG   = 2'b00,
    OP_SERASE = 2'b01,
    OP_CERASE = 2'b10,
    OP_ABORT  = 2'b11
  } op_e;

  // bottom-boot map in units: 2,1,1,4, then 8 x7
  function automatic int sec_of_unit(int u);
    if (u < 2) return 0;
    if (u == 2) return 1;
    if (u == 3) return 2;
    if (u < 8) return 3;
    return 4 + ((u - 8) >> 3);
  endfunction

  function automatic int base_unit(int s);
    case (s)
      0: return 0;
      1: return 2;
      2: return 3;
      3: return 4;
      default: return 8 * (s - 3);
    endcase
  endfunction
endpackage

// File: rtl/flash_sec_dec.sv
module flash_sec_dec
  import flash_emu_pkg::*;
#(
  parameter int SEC_UNIT = 8,
  parameter int AW = $clog2(SEC_UNIT) + 6
) (
  input  logic [AW-1:0] addr_i,
  output logic [3:0]    sec_o,
  output logic [AW-1:0] off_o
);
  localparam int UW = $clog2(SEC_UNIT);

  int s;
  always_comb begin
    s = sec_of_unit(int'(addr_i >> UW));
    sec_o = 4'(s);
    off_o = addr_i - AW'(base_unit(s) << UW);
  end
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_emu_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 16,
  parameter int BUSY_CYC = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [1:0]      op_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [3:0]      sec_i,
  input  logic [NSEC-1:0] prot_i,
  input  logic            unprot_i,
  output logic            ack_o,
  output logic            busy_o,
  output logic            prog_o,
  output logic [NSEC-1:0] erase_o,
  output logic [AW-1:0]   caddr_o,
  output logic [DW-1:0]   cdata_o
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic            busy_q, ack_q;
  logic [CW-1:0]   cnt_q;
  op_e             op_q;
  logic [3:0]      sec_q;
  logic [NSEC-1:0] lock_q;
  logic            abort, done;

  assign abort = req_i && (op_e'(op_i) == OP_ABORT);
  assign done  = busy_q && (cnt_q == '0) && !abort;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      ack_q   <= 1'b0;
      cnt_q   <= '0;
      op_q    <= OP_PROG;
      sec_q   <= '0;
      lock_q  <= '0;
      caddr_o <= '0;
      cdata_o <= '0;
    end else begin
      ack_q <= 1'b0;
      if (abort) begin
        busy_q <= 1'b0;
        ack_q  <= 1'b1;
      end else if (req_i && !busy_q) begin
        busy_q  <= 1'b1;
        ack_q   <= 1'b1;
        cnt_q   <= CW'(BUSY_CYC - 1);
        op_q    <= op_e'(op_i);
        sec_q   <= sec_i;
        lock_q  <= prot_i & ~{NSEC{unprot_i}};
        caddr_o <= addr_i;
        cdata_o <= wdata_i;
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign ack_o  = ack_q;
  assign busy_o = busy_q;
  assign prog_o = done && (op_q == OP_PROG) && !lock_q[sec_q];

  for (genvar s = 0; s < NSEC; s++) begin : g_erase
    assign erase_o[s] = done && !lock_q[s] &&
                        ((op_q == OP_CERASE) || (op_q == OP_SERASE && sec_q == 4'(s)));
  end
endmodule

// File: rtl/flash_array_emu.sv
module flash_array_emu
  import flash_emu_pkg::*;
#(
  parameter int SEC_UNIT = 8,
  parameter int DW = 16,
  parameter int BUSY_CYC = 4,
  parameter logic [DW-1:0] DEV_ID = DW'(16'h22BA),
  parameter int AW = $clog2(SEC_UNIT) + 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [1:0]      op_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NSEC-1:0] prot_i,
  input  logic            unprot_i,
  input  logic            id_mode_i,
  output logic            ack_o,
  output logic            busy_o,
  output logic [DW-1:0]   rdata_o
);
  localparam int UW = $clog2(SEC_UNIT);
  localparam int WORDS = NUNITS * SEC_UNIT;

  logic [3:0]      sec;
  logic [AW-1:0]   off;
  logic            prog_w;
  logic [NSEC-1:0] erase_w;
  logic [AW-1:0]   caddr;
  logic [DW-1:0]   cdata;
  logic [DW-1:0]   mem [WORDS];

  flash_sec_dec #(.SEC_UNIT(SEC_UNIT), .AW(AW)) u_dec (
    .addr_i(addr_i), .sec_o(sec), .off_o(off)
  );

  flash_ctrl #(.AW(AW), .DW(DW), .BUSY_CYC(BUSY_CYC)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .op_i(op_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .sec_i(sec), .prot_i(prot_i),
    .unprot_i(unprot_i), .ack_o(ack_o), .busy_o(busy_o), .prog_o(prog_w),
    .erase_o(erase_w), .caddr_o(caddr), .cdata_o(cdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < WORDS; i++)
        if (erase_w[sec_of_unit(i >> UW)]) mem[i] <= '1;
      if (prog_w) mem[caddr] <= mem[caddr] & cdata;
    end
  end

  always_comb begin
    rdata_o = mem[addr_i];
    if (id_mode_i) begin
      case (off)
        AW'(0):  rdata_o = DW'(8'h52);
        AW'(1):  rdata_o = DEV_ID;
        AW'(2):  rdata_o = {{(DW-1){1'b0}}, prot_i[sec]};
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/flash_array_emu_chk.sv
module flash_array_emu_chk
  import flash_emu_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 9,
  parameter int BUSY_CYC = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic [1:0]    op_i,
  input logic [AW-1:0] addr_i,
  input logic          id_mode_i,
  input logic          ack_o,
  input logic          busy_o,
  input logic [DW-1:0] rdata_o
);
  logic [31:0] bcnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bcnt <= '0;
    else if (busy_o) bcnt <= bcnt + 1;
    else bcnt <= '0;
  end

  // R9
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> bcnt < BUSY_CYC);

  // R9
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && op_i != 2'b11) |=> (ack_o && busy_o));

  // R10
  reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && busy_o && op_i != 2'b11) |=> !ack_o);

  // R11
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == 2'b11) |=> (ack_o && !busy_o));

  // R8
  id_mfr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_mode_i && addr_i == '0) |-> rdata_o == DW'(8'h52));
endmodule

bind flash_array_emu flash_array_emu_chk #(.DW(DW), .AW(AW), .BUSY_CYC(BUSY_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .op_i(op_i), .addr_i(addr_i),
  .id_mode_i(id_mode_i), .ack_o(ack_o), .busy_o(busy_o), .rdata_o(rdata_o)
);

// File: tb/sim_flash_array_emu.sv
module sim_flash_array_emu;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_CYC = 4;
  localparam logic [15:0] DEV = 16'h22BA;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0;
  logic [1:0] op_i = 2'b00;
  logic [8:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [10:0] prot_i = '0;
  logic unprot_i = 1'b0;
  logic id_mode_i = 1'b0;
  logic ack_o, busy_o;
  logic [15:0] rdata_o;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_array_emu #(.SEC_UNIT(8), .DW(16), .BUSY_CYC(BUSY_CYC), .DEV_ID(DEV)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .op_i(op_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .prot_i(prot_i), .unprot_i(unprot_i), .id_mode_i(id_mode_i),
    .ack_o(ack_o), .busy_o(busy_o), .rdata_o(rdata_o)
  );

  // {op, addr, wdata, check addr, expected}
  localparam logic [51:0] VEC [14] = '{
    {2'd0, 9'd0,   16'hA5A5, 9'd0,   16'hA5A5},  // R3
    {2'd0, 9'd0,   16'h0FF0, 9'd0,   16'h05A0},  // R3 AND rule
    {2'd0, 9'd15,  16'h1234, 9'd15,  16'h1234},  // R3
    {2'd0, 9'd16,  16'hBEEF, 9'd16,  16'hBEEF},  // R3
    {2'd1, 9'd0,   16'h0000, 9'd0,   16'hFFFF},  // R4
    {2'd1, 9'd7,   16'h0000, 9'd16,  16'hBEEF},  // R1 sector0 ends at 15
    {2'd0, 9'd500, 16'hC3C3, 9'd500, 16'hC3C3},  // R3
    {2'd1, 9'd16,  16'h0000, 9'd16,  16'hFFFF},  // R4
    {2'd0, 9'd23,  16'h0001, 9'd23,  16'h0001},  // R3
    {2'd1, 9'd24,  16'h0000, 9'd23,  16'h0001},  // R1 sector1 ends at 23
    {2'd0, 9'd63,  16'h7777, 9'd63,  16'h7777},  // R3
    {2'd1, 9'd64,  16'h0000, 9'd63,  16'h7777},  // R1 sector3 ends at 63
    {2'd2, 9'd0,   16'h0000, 9'd500, 16'hFFFF},  // R5
    {2'd0, 9'd100, 16'h0000, 9'd100, 16'h0000}   // R3
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [8:0] a, output logic [15:0] v);
    @(negedge clk);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  task automatic do_op(input logic [1:0] op, input logic [8:0] a, input logic [15:0] d,
                       output int blen);
    @(negedge clk);
    req_i = 1'b1; op_i = op; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0;
    chk("R9 ack", {15'b0, ack_o}, 16'd1);
    blen = 0;
    while (busy_o) begin
      blen++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R2 reset state
    rd(9'd0, v);   chk("R2 word0", v, 16'hFFFF);
    rd(9'd511, v); chk("R2 word511", v, 16'hFFFF);
    chk("R2 busy/ack", {14'b0, busy_o, ack_o}, 16'd0);

    for (int i = 0; i < 14; i++) begin
      do_op(VEC[i][51:50], VEC[i][49:41], VEC[i][40:25], n);
      rd(VEC[i][24:16], v);
      chk($sformatf("R1/R3/R4/R5 vector %0d", i), v, VEC[i][15:0]);
    end

    // R9 busy length
    do_op(2'd0, 9'd300, 16'h00FF, n);
    chk("R9 busy length", 16'(n), 16'(BUSY_CYC));
    rd(9'd300, v); chk("R9 commit", v, 16'h00FF);

    // R10 reject while busy
    @(negedge clk);
    req_i = 1'b1; op_i = 2'd0; addr_i = 9'd200; wdata_i = 16'h0000;
    @(negedge clk);
    addr_i = 9'd201;
    @(negedge clk);
    req_i = 1'b0;
    chk("R10 no ack", {15'b0, ack_o}, 16'd0);
    while (busy_o) @(negedge clk);
    rd(9'd200, v); chk("R10 first done", v, 16'h0000);
    rd(9'd201, v); chk("R10 second ignored", v, 16'hFFFF);

    // R11 abort
    @(negedge clk);
    req_i = 1'b1; op_i = 2'd0; addr_i = 9'd202; wdata_i = 16'h0000;
    @(negedge clk);
    op_i = 2'd3;
    @(negedge clk);
    req_i = 1'b0;
    chk("R11 ack/busy", {14'b0, busy_o, ack_o}, 16'd1);
    repeat (BUSY_CYC + 2) @(negedge clk);
    rd(9'd202, v); chk("R11 discarded", v, 16'hFFFF);

    // R6 protection (sector 5 = words 128..191)
    do_op(2'd0, 9'd140, 16'h1111, n);
    prot_i = 11'b000_0010_0000;
    do_op(2'd0, 9'd130, 16'h0000, n);
    rd(9'd130, v); chk("R6 program blocked", v, 16'hFFFF);
    do_op(2'd1, 9'd140, 16'h0000, n);
    rd(9'd140, v); chk("R6 erase blocked", v, 16'h1111);
    do_op(2'd2, 9'd0, 16'h0000, n);
    rd(9'd140, v); chk("R6 chip erase skips", v, 16'h1111);
    rd(9'd100, v); chk("R5 chip erase others", v, 16'hFFFF);

    // R7 temporary unprotect
    unprot_i = 1'b1;
    do_op(2'd0, 9'd130, 16'h00F0, n);
    unprot_i = 1'b0;
    rd(9'd130, v); chk("R7 lifted", v, 16'h00F0);
    do_op(2'd0, 9'd130, 16'h0000, n);
    rd(9'd130, v); chk("R7 restored", v, 16'h00F0);

    // R8 ID mode
    id_mode_i = 1'b1;
    rd(9'd0, v);   chk("R8 mfr", v, 16'h0052);
    rd(9'd1, v);   chk("R8 device", v, DEV);
    rd(9'd130, v); chk("R8 prot set", v, 16'h0001);
    rd(9'd66, v);  chk("R8 prot clear", v, 16'h0000);
    rd(9'd3, v);   chk("R8 other offset", v, 16'h0000);
    id_mode_i = 1'b0;
    rd(9'd140, v); chk("R8 array intact", v, 16'h1111);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule